// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block sequences the high-side and low-side switch requests of one synchronous buck phase from a single PWM command. Dead time is not a fixed count: each turn-on waits for evidence from external comparators that the opposite switch has actually let go. A rising command drops the low-side request and holds the high side off until the low-side gate is reported discharged, plus a short settling count. A falling command drops the high-side request and holds the low side off until the switching node is reported low. If the switching node never reports low, a timeout turns the low side on anyway. This keeps reverse-current and crowbar operation working.

Very narrow command pulses are not passed through as slivers. Every high-side pulse lasts at least a minimum on-time. Every low-side off interval lasts at least a minimum off-time. An enable input and an already-filtered supply-good flag force both requests low. After any shutdown the sequencer restarts only through the low-side-on state, and only once the command is low. All times are counts of the block clock.

Top module: `nov_gate_seq`

## Requirements
- R1: While reset is applied, both gate requests are low. One clock after `supply_ok_i` goes low, both requests are low. They stay low for as long as the flag stays low.
- R2: Three clocks after `en_i` goes low, both requests are low, even if the high side was conducting.
- R3: `hs_gate_o` and `ls_gate_o` are never high in the same cycle.
- R4: `ls_gate_o` falls three clocks after `pwm_i` rises. `hs_gate_o` rises SETTLE_CYC+3 clocks after `ls_low_i` goes high. With feedback that follows the gate half a clock later, this gives a rise 5 clocks after the low-side fall.
- R5: `hs_gate_o` falls three clocks after `pwm_i` falls, once the minimum on-time is met. `ls_gate_o` rises three clocks after `sw_low_i` goes high, once the minimum off-time is met.
- R6: If `sw_low_i` stays low, `ls_gate_o` rises LS_TMO_CYC (default 35) clocks after `hs_gate_o` falls.
- R7: Every command pulse of at least one clock produces a high-side pulse. Its width is the larger of MIN_ON_CYC (default 8) and the width the command alone would give.
- R8: Each low-side off interval lasts at least MIN_OFF_CYC (default 28) clocks.
- R9: After reset, disable or supply loss, the low side is the first to turn on. Neither request rises while `pwm_i` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_i | input | 1 | PWM command, high requests the high side |
| en_i | input | 1 | Enable, low forces both requests off |
| supply_ok_i | input | 1 | Filtered supply-good flag, used unsynchronised |
| ls_low_i | input | 1 | Low-side gate is below its turn-off threshold |
| sw_low_i | input | 1 | Switching node is below its threshold |
| hs_gate_o | output | 1 | High-side gate request |
| ls_gate_o | output | 1 | Low-side gate request |

## Verification
The assertions check four things on every cycle: the two requests never overlap, each request rises only after the other was already low, neither request outlives a supply or enable drop, and pulse widths respect the minimum on-time and minimum off-time. Only the bench scenarios can show the exact latencies. These are the adaptive dead time measured from modelled feedback, the forced low-side turn-on when the switching node is held high, the stretching of narrow and random command pulses, and the refusal to resume while the command is still high.

// File: rtl/nov_pkg.sv
package nov_pkg;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_LS_ON     = 3'd1,
    ST_HS_WAIT   = 3'd2,
    ST_HS_SETTLE = 3'd3,
    ST_HS_ON     = 3'd4,
    ST_LS_WAIT   = 3'd5
  } nov_state_e;

  function automatic int unsigned nov_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nov_sync.sv
module nov_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/nov_timer.sv
module nov_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);
  assign cnt_d  = load_i ? val_i : (cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/nov_gate_seq.sv
module nov_gate_seq
  import nov_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_ON_CYC  = 8,   // >= 1
  parameter int unsigned MIN_OFF_CYC = 28,  // >= 1
  parameter int unsigned LS_TMO_CYC  = 35,  // >= 1
  parameter int unsigned SETTLE_CYC  = 2    // >= 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic ls_low_i,
  input  logic sw_low_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);

  localparam int unsigned PH_MAX = nov_max3(SETTLE_CYC - 1, MIN_ON_CYC - 1, LS_TMO_CYC - 1);
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1) < 1 ? 1 : $clog2(PH_MAX + 1);
  localparam int unsigned OFF_W  = $clog2(MIN_OFF_CYC) < 1 ? 1 : $clog2(MIN_OFF_CYC);
  localparam int unsigned HSR_W  = $clog2(MIN_ON_CYC + 1);
  localparam int unsigned LSR_W  = $clog2(MIN_OFF_CYC + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // input synchronisers
  logic pwm_s, en_s, ls_low_s, sw_low_s;

  nov_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({pwm_i, en_i, ls_low_i, sw_low_i}),
    .q_o   ({pwm_s, en_s, ls_low_s, sw_low_s})
  );

  // state and outputs
  nov_state_e state_q, state_d;
  logic       hs_q, ls_q;
  logic       run_ok;
  logic            ph_load, ph_done;
  logic [PH_W-1:0] ph_val;
  logic            off_load, off_done;

  assign run_ok = en_s && supply_ok_i;

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    if (!run_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (!pwm_s && off_done) state_d = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (pwm_s) state_d = ST_HS_WAIT;
        end
        ST_HS_WAIT: begin
          if (ls_low_s) begin
            state_d = ST_HS_SETTLE;
            ph_load = 1'b1;
            ph_val  = PH_W'(SETTLE_CYC - 1);
          end
        end
        ST_HS_SETTLE: begin
          if (ph_done) begin
            state_d = ST_HS_ON;
            ph_load = 1'b1;
            ph_val  = PH_W'(MIN_ON_CYC - 1);
          end
        end
        ST_HS_ON: begin
          if (!pwm_s && ph_done) begin
            state_d = ST_LS_WAIT;
            ph_load = 1'b1;
            ph_val  = PH_W'(LS_TMO_CYC - 1);
          end
        end
        ST_LS_WAIT: begin
          if ((sw_low_s || ph_done) && off_done) state_d = ST_LS_ON;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  // off window starts whenever the low-side request drops
  assign off_load = ls_q && (state_d != ST_LS_ON);

  nov_timer #(.W(PH_W)) u_ph_tmr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (ph_load),
    .val_i  (ph_val),
    .done_o (ph_done)
  );

  nov_timer #(.W(OFF_W)) u_off_tmr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (off_load),
    .val_i  (OFF_W'(MIN_OFF_CYC - 1)),
    .done_o (off_done)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_OFF;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_q    <= (state_d == ST_HS_ON);
      ls_q    <= (state_d == ST_LS_ON);
    end
  end

  assign hs_gate_o = hs_q;
  assign ls_gate_o = ls_q;

  // width monitors for the assertions below
  logic [HSR_W-1:0] hs_run_q;
  logic [LSR_W-1:0] ls_off_run_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                          hs_run_q <= '0;
    else if (!hs_q)                           hs_run_q <= '0;
    else if (hs_run_q < HSR_W'(MIN_ON_CYC))   hs_run_q <= hs_run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                          ls_off_run_q <= LSR_W'(MIN_OFF_CYC);
    else if (ls_q)                            ls_off_run_q <= '0;
    else if (ls_off_run_q < LSR_W'(MIN_OFF_CYC)) ls_off_run_q <= ls_off_run_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(hs_q && ls_q)); // R3

  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(hs_q) |-> !$past(ls_q)); // R4

  AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ls_q) |-> !$past(hs_q)); // R5

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !supply_ok_i |=> (!hs_q && !ls_q)); // R1

  AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_core_n)
    !en_s |=> (!hs_q && !ls_q)); // R2

  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($fell(hs_q) && state_q != ST_OFF) |-> (hs_run_q >= HSR_W'(MIN_ON_CYC))); // R7

  AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ls_q) |-> (ls_off_run_q >= LSR_W'(MIN_OFF_CYC))); // R8

  AST_RESUME_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($rose(ls_q) && $past(state_q) == ST_OFF) |-> !$past(pwm_s)); // R9

endmodule

// File: tb/nov_gate_seq_tb.sv
module nov_gate_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_ON     = 8;
  localparam int MIN_OFF    = 28;
  localparam int LS_TMO     = 35;
  localparam int DEAD_RISE  = 5;  // sync + feedback + settle
  localparam int FB_FALL    = 3;  // sync + feedback on the falling side

  logic clk, rst_n, pwm, en, sup_ok, ls_low, sw_low, stuck;
  logic hs, ls;

  int n_total = 0;
  int n_bad   = 0;
  int overlap = 0;
  bit mon_on  = 0;

  typedef struct { int hw; int dead; int off; bit stk; } exp_t;
  exp_t exp_q[$];

  nov_gate_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_i       (pwm),
    .en_i        (en),
    .supply_ok_i (sup_ok),
    .ls_low_i    (ls_low),
    .sw_low_i    (sw_low),
    .hs_gate_o   (hs),
    .ls_gate_o   (ls)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: feedback follows the gates half a clock later
  initial begin ls_low = 1'b1; sw_low = 1'b1; end
  always @(negedge clk) begin
    ls_low <= !ls;
    sw_low <= stuck ? 1'b0 : !hs;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures pulses and compares with queued expectations
  int  off_cnt = 0, hs_cnt = 0, dead_seen = 0, hw_seen = 0;
  bit  hs_prev = 0, ls_prev = 1;
  always @(negedge clk) begin
    if (mon_on) begin
      if (hs && ls) overlap++;
      if (hs && !hs_prev) dead_seen = off_cnt;
      if (!hs && hs_prev) hw_seen = hs_cnt;
      if (ls && !ls_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected low-side turn-on", off_cnt, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(hw_seen == e.hw, "R7 high-side width", hw_seen, e.hw);
          chk(dead_seen == e.dead, "R4 rising dead time", dead_seen, e.dead);
          if (e.off == MIN_OFF)
            chk(off_cnt == e.off, "R8 low-side off width", off_cnt, e.off);
          else if (e.stk)
            chk(off_cnt == e.off, "R6 forced low-side timeout", off_cnt, e.off);
          else
            chk(off_cnt == e.off, "R5 adaptive low-side return", off_cnt, e.off);
        end
        off_cnt = 0;
      end
      if (!ls) off_cnt++;
      if (hs) hs_cnt++; else hs_cnt = 0;
    end
    hs_prev = hs;
    ls_prev = ls;
  end

  task automatic pulse(input int w, input bit stk);
    exp_t e;
    int   hw;
    hw    = (w - DEAD_RISE > MIN_ON) ? w - DEAD_RISE : MIN_ON;
    e.hw   = hw;
    e.dead = DEAD_RISE;
    e.off  = DEAD_RISE + hw + (stk ? LS_TMO : FB_FALL);
    if (e.off < MIN_OFF) e.off = MIN_OFF;
    e.stk  = stk;
    @(negedge clk);
    stuck = stk;
    exp_q.push_back(e);
    pwm = 1'b1;
    repeat (w) @(negedge clk);
    pwm = 1'b0;
    repeat (110) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; sup_ok = 1'b1; pwm = 1'b0; stuck = 1'b0;
    repeat (5) @(negedge clk);
    chk(hs == 1'b0, "R1 high side in reset", hs, 0);
    chk(ls == 1'b0, "R1 low side in reset", ls, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(ls == 1'b1, "R9 low side first after reset", ls, 1);
    chk(hs == 1'b0, "R9 high side idle after reset", hs, 0);

    mon_on = 1;
    pulse(1, 0); pulse(3, 0); pulse(5, 0); pulse(6, 0);
    pulse(13, 0); pulse(20, 0); pulse(40, 0);
    for (int i = 0; i < 10; i++) pulse($urandom_range(1, 12), 0);
    pulse(2, 1); pulse(10, 1); pulse(30, 1);
    pulse(4, 0);
    mon_on = 0;
    chk(exp_q.size() == 0, "R7 every pulse answered", exp_q.size(), 0);

    // disable while the high side conducts
    @(negedge clk); pwm = 1'b1;
    repeat (12) @(negedge clk);
    chk(hs == 1'b1, "R2 high side on before disable", hs, 1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(hs == 1'b1, "R2 high side still on two clocks after disable", hs, 1);
    @(negedge clk);
    chk(!hs && !ls, "R2 both off three clocks after disable", {hs, ls}, 0);
    repeat (5) @(negedge clk);
    en = 1'b1;
    repeat (30) @(negedge clk);
    chk(!hs && !ls, "R9 no resume while pwm high", {hs, ls}, 0);
    pwm = 1'b0;
    repeat (8) @(negedge clk);
    chk(ls == 1'b1 && hs == 1'b0, "R9 resume with low side", {hs, ls}, 1);

    // supply loss
    sup_ok = 1'b0;
    @(negedge clk);
    chk(!hs && !ls, "R1 off one clock after supply loss", {hs, ls}, 0);
    repeat (40) @(negedge clk);
    chk(!hs && !ls, "R1 held off during supply loss", {hs, ls}, 0);
    sup_ok = 1'b1;
    repeat (40) @(negedge clk);
    chk(ls == 1'b1, "R1 low side back after supply return", ls, 1);

    chk(overlap == 0, "R3 no overlap during pulses", overlap, 0);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule